// File: doc/BRIEF.md
# High-Speed UART Receive FIFO

This block is the receive side of a fixed-format serial port. The frame is always 8 data bits, least significant bit first, no parity and one stop bit. The serial input passes through a two-flop synchronizer and is sampled 14 times per bit. The oversample tick is derived from the core clock through a programmable divider. Every character received, whether clean, framing-errored or a break, goes into a 64-entry FIFO. Each entry carries its own error and break tags.

Software or a DMA engine reads a 32-bit word from the head of the FIFO. That word holds the byte, an empty marker, and the error and break tags of that byte. Reading also pops the entry. A level output gives the current fill count.

Two groups of conditions drive a single interrupt line:
- **Data conditions**, which follow the FIFO state: the fill level reaching a selectable threshold, and an inactivity timeout counted in character times.
- **Error conditions**, which are sticky: overrun, break and framing error. Each is cleared by writing a 1 to its clear bit.

Top module: `hs_uart_rx`

## Requirements
- R1: `popData` holds the head entry as follows: byte in bits 7:0, framing-error tag in bit 9, break tag in bit 10, all other bits zero. While the FIFO is empty, `popData` reads 32'h0000_0100 (bit 8 set).
- R2: The receiver decodes 8N1 frames, least significant bit first, at 14 oversample ticks per bit. One tick occurs every `rateDiv`+1 clock cycles.
- R3: The FIFO holds up to 64 entries and returns them in arrival order. `rxLevel` gives the fill count. A `popReq` high at a clock edge removes one entry if the FIFO is not empty.
- R4: `intStatus` bit 1 is high whenever `rxLevel` is at or above the threshold chosen by `trigSel`:

  | `trigSel` | Threshold |
  |---|---|
  | 0 | 1 |
  | 1 | 4 |
  | 2 | 8 |
  | 3 | 16 |
  | 4 | 32 |
  | 5, 6, 7 | 48 |

- R5: A frame whose stop bit samples low and whose data is nonzero is stored with bit 9 set. It also sets the sticky framing flag, `intStatus` bit 3.
- R6: A frame that is low through its whole length, stop position included, stores exactly one entry. That entry has data 0 and bit 10 set, and the sticky break flag (`intStatus` bit 4) is set. No new frame is accepted until the line has returned high.
- R7: The sticky flags are cleared by a 1 on `clrFlags`: bit 0 clears framing, bit 1 clears break, bit 2 clears overrun. If a flag is set and cleared in the same cycle, the set wins.
- R8: A character that completes while the FIFO holds 64 entries is discarded and the stored entries are kept. The sticky overrun flag (`intStatus` bit 5) is set.
- R9: `intStatus` bit 2 rises once the FIFO has been non-empty with no push and no pop for N character times, where one character time is 140 ticks. N is selected by `tmoSel`:

  | `tmoSel` | N |
  |---|---|
  | 0 | timeout disabled |
  | 1 | 4 |
  | 2 | 8 |
  | 3 | 16 |

  A push or a pop clears bit 2 and restarts the count.
- R10: A low pulse on `serialIn` that has ended before the mid-bit check (sample 7 after detection) is ignored. No entry is stored.
- R11: `irq` is given by

  `irq = (rxIntEn & (intStatus[1] | intStatus[2])) | (errIntEn & (intStatus[3] | intStatus[4] | intStatus[5]))`

  `intStatus` bit 0 always reads 0.
- R12: After reset the FIFO is empty, all status bits are 0 and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low synchronous reset |
| serialIn | input | 1 | Asynchronous serial receive line, idle high |
| rateDiv | input | 8 | Oversample tick every rateDiv+1 clocks |
| trigSel | input | 3 | Fill-level trigger select |
| tmoSel | input | 2 | Inactivity timeout select |
| rxIntEn | input | 1 | Enables the trigger and timeout interrupt sources |
| errIntEn | input | 1 | Enables the overrun, break and framing interrupt sources |
| popReq | input | 1 | Pops the head entry at this clock edge |
| clrFlags | input | 3 | Write-1-to-clear for the framing, break and overrun flags |
| popData | output | 32 | Head entry with empty, error and break tags |
| rxLevel | output | 8 | Current FIFO fill count |
| intStatus | output | 6 | Status bits: overrun, break, framing, timeout, trigger, 0 |
| irq | output | 1 | Combined interrupt request |

## Verification
The receiver is tested with a range of serial patterns:
- **Alternating and extreme bytes** (0x55, 0xA3, 0x00, 0xFF) prove bit order and sample placement, including the case where data 0x00 with a good stop bit must not be taken for a break.
- **A short glitch, a stop-low frame and a long-low break** separate the three start and stop outcomes.
- **A 65-character burst without reads** shows that overrun drops the newest byte and keeps all the older ones.
- **Single characters left unread** under timeout codes 0, 1 and 3 show that the inactivity count scales with the code and is cleared by a pop.

// File: rtl/hs_uart_rx_pkg.sv
package hs_uart_rx_pkg;

  // One received character handed from the control to the datapath
  typedef struct packed {
    logic       push;
    logic [7:0] data;
    logic       err;
    logic       brk;
  } rxPush_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP,
    ST_WAITHI
  } rxState_e;

endpackage

// File: rtl/hs_uart_rx_fifo.sv
module hs_uart_rx_fifo
  import hs_uart_rx_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = AW + 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  rxPush_t       pushStb,
  input  logic          popReq,
  output logic [LW-1:0] level,
  output logic          full,
  output logic [31:0]   readWord
);

  // entry layout: {brk, err, data}
  logic [9:0]    mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic          doPush, doPop, empty;

  assign empty  = (level == '0);
  assign full   = (level == LW'(DEPTH));
  assign doPush = pushStb.push && !full;
  assign doPop  = popReq && !empty;

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= {pushStb.brk, pushStb.err, pushStb.data};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      if (doPush) wrPtr <= wrPtr + 1'b1;
      if (doPop)  rdPtr <= rdPtr + 1'b1;
      case ({doPush, doPop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  always_comb begin
    if (empty) readWord = 32'h0000_0100;
    else       readWord = {21'd0, mem[rdPtr][9], mem[rdPtr][8], 1'b0, mem[rdPtr][7:0]};
  end

endmodule

// File: rtl/hs_uart_rx_ctrl.sv
module hs_uart_rx_ctrl
  import hs_uart_rx_pkg::*;
#(
  parameter int OVS   = 14,
  parameter int DEPTH = 64,
  localparam int LW   = $clog2(DEPTH) + 1,
  localparam int SW   = $clog2(OVS),
  localparam int MID  = OVS / 2,
  localparam int CHAR_TICKS = 10 * OVS,
  localparam int TW   = $clog2(16 * CHAR_TICKS + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          serialIn,
  input  logic [7:0]    rateDiv,
  input  logic [2:0]    trigSel,
  input  logic [1:0]    tmoSel,
  input  logic          rxIntEn,
  input  logic          errIntEn,
  input  logic          popReq,
  input  logic [2:0]    clrFlags,
  input  logic [LW-1:0] level,
  input  logic          full,
  output rxPush_t       pushStb,
  output logic [5:0]    intStatus,
  output logic          irq
);

  // oversample tick
  logic [7:0] divCnt;
  logic       tick;
  assign tick = (divCnt == rateDiv);

  always_ff @(posedge clk) begin
    if (!rstN || tick) divCnt <= '0;
    else               divCnt <= divCnt + 1'b1;
  end

  // input synchronizer
  logic syncA, rxS;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA <= 1'b1;
      rxS   <= 1'b1;
    end else begin
      syncA <= serialIn;
      rxS   <= syncA;
    end
  end

  // frame sampler
  rxState_e      state;
  logic [SW-1:0] smp;
  logic [2:0]    bitIdx;
  logic [7:0]    shReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      smp     <= '0;
      bitIdx  <= '0;
      shReg   <= '0;
      pushStb <= '0;
    end else begin
      pushStb.push <= 1'b0;
      if (tick) begin
        case (state)
          ST_IDLE: begin
            smp <= '0;
            if (!rxS) state <= ST_START;
          end
          ST_START: begin
            if (smp == SW'(MID - 1)) begin
              smp    <= '0;
              bitIdx <= '0;
              state  <= rxS ? ST_IDLE : ST_DATA;
            end else begin
              smp <= smp + 1'b1;
            end
          end
          ST_DATA: begin
            if (smp == SW'(OVS - 1)) begin
              smp   <= '0;
              shReg <= {rxS, shReg[7:1]};
              if (bitIdx == 3'd7) state <= ST_STOP;
              else                bitIdx <= bitIdx + 1'b1;
            end else begin
              smp <= smp + 1'b1;
            end
          end
          ST_STOP: begin
            if (smp == SW'(OVS - 1)) begin
              smp          <= '0;
              pushStb.push <= 1'b1;
              pushStb.data <= shReg;
              pushStb.err  <= !rxS && (shReg != 8'd0);
              pushStb.brk  <= !rxS && (shReg == 8'd0);
              state        <= rxS ? ST_IDLE : ST_WAITHI;
            end else begin
              smp <= smp + 1'b1;
            end
          end
          ST_WAITHI: if (rxS) state <= ST_IDLE;
          default:   state <= ST_IDLE;
        endcase
      end
    end
  end

  // sticky error flags
  logic fltFe, fltBrk, fltOvr;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      fltFe  <= 1'b0;
      fltBrk <= 1'b0;
      fltOvr <= 1'b0;
    end else begin
      fltFe  <= (pushStb.push && pushStb.err) || (fltFe  && !clrFlags[0]);
      fltBrk <= (pushStb.push && pushStb.brk) || (fltBrk && !clrFlags[1]);
      fltOvr <= (pushStb.push && full)        || (fltOvr && !clrFlags[2]);
    end
  end

  // fill trigger
  logic [LW-1:0] trigLvl;
  always_comb begin
    case (trigSel)
      3'd0:    trigLvl = LW'(1);
      3'd1:    trigLvl = LW'(4);
      3'd2:    trigLvl = LW'(8);
      3'd3:    trigLvl = LW'(16);
      3'd4:    trigLvl = LW'(32);
      default: trigLvl = LW'(48);
    endcase
  end

  logic trigHit;
  assign trigHit = (level >= trigLvl);

  // inactivity timeout
  logic [TW-1:0] tmoLimit, tmoCnt;
  logic          tmoHit, tmoRestart;

  always_comb begin
    case (tmoSel)
      2'd1:    tmoLimit = TW'(4 * CHAR_TICKS);
      2'd2:    tmoLimit = TW'(8 * CHAR_TICKS);
      2'd3:    tmoLimit = TW'(16 * CHAR_TICKS);
      default: tmoLimit = '0;
    endcase
  end

  assign tmoRestart = pushStb.push || popReq || (level == '0) || (tmoSel == 2'd0);

  always_ff @(posedge clk) begin
    if (!rstN || tmoRestart) begin
      tmoCnt <= '0;
      tmoHit <= 1'b0;
    end else if (tick && !tmoHit) begin
      if (tmoCnt == tmoLimit - 1'b1) tmoHit <= 1'b1;
      else                           tmoCnt <= tmoCnt + 1'b1;
    end
  end

  assign intStatus = {fltOvr, fltBrk, fltFe, tmoHit, trigHit, 1'b0};
  assign irq = (rxIntEn && (trigHit || tmoHit)) ||
               (errIntEn && (fltOvr || fltBrk || fltFe));

endmodule

// File: rtl/hs_uart_rx.sv
module hs_uart_rx
  import hs_uart_rx_pkg::*;
#(
  parameter int OVS   = 14,
  parameter int DEPTH = 64,
  localparam int LW   = $clog2(DEPTH) + 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        serialIn,
  input  logic [7:0]  rateDiv,
  input  logic [2:0]  trigSel,
  input  logic [1:0]  tmoSel,
  input  logic        rxIntEn,
  input  logic        errIntEn,
  input  logic        popReq,
  input  logic [2:0]  clrFlags,
  output logic [31:0] popData,
  output logic [7:0]  rxLevel,
  output logic [5:0]  intStatus,
  output logic        irq
);

  rxPush_t       pushStb;
  logic [LW-1:0] level;
  logic          full;

  hs_uart_rx_ctrl #(.OVS(OVS), .DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .serialIn(serialIn), .rateDiv(rateDiv),
    .trigSel(trigSel), .tmoSel(tmoSel), .rxIntEn(rxIntEn), .errIntEn(errIntEn),
    .popReq(popReq), .clrFlags(clrFlags), .level(level), .full(full),
    .pushStb(pushStb), .intStatus(intStatus), .irq(irq)
  );

  hs_uart_rx_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rstN(rstN), .pushStb(pushStb), .popReq(popReq),
    .level(level), .full(full), .readWord(popData)
  );

  assign rxLevel = 8'(level);

endmodule

// File: rtl/hs_uart_rx_chk.sv
module hs_uart_rx_chk #(
  parameter int DEPTH = 64
) (
  input logic        clk,
  input logic        rstN,
  input logic        popReq,
  input logic [2:0]  clrFlags,
  input logic        rxIntEn,
  input logic        errIntEn,
  input logic [31:0] popData,
  input logic [7:0]  rxLevel,
  input logic [5:0]  intStatus,
  input logic        irq
);

  a_r1_empty_word: assert property (@(posedge clk) disable iff (!rstN)
    (rxLevel == 8'd0) |-> (popData == 32'h0000_0100));

  a_r1_full_word: assert property (@(posedge clk) disable iff (!rstN)
    (rxLevel != 8'd0) |-> (!popData[8] && popData[31:11] == 21'd0));

  a_r3_level_bound: assert property (@(posedge clk) disable iff (!rstN)
    int'(rxLevel) <= DEPTH);

  a_r3_level_step: assert property (@(posedge clk) disable iff (!rstN)
    (rxLevel != 8'd0) && !popReq |=> (rxLevel >= $past(rxLevel)));

  a_r8_full_hold: assert property (@(posedge clk) disable iff (!rstN)
    (int'(rxLevel) == DEPTH) && !popReq |=> (int'(rxLevel) == DEPTH));

  a_r7_ovr_sticky: assert property (@(posedge clk) disable iff (!rstN)
    intStatus[5] && !clrFlags[2] |=> intStatus[5]);

  a_r7_brk_sticky: assert property (@(posedge clk) disable iff (!rstN)
    intStatus[4] && !clrFlags[1] |=> intStatus[4]);

  a_r7_fe_sticky: assert property (@(posedge clk) disable iff (!rstN)
    intStatus[3] && !clrFlags[0] |=> intStatus[3]);

  a_r11_irq_masked: assert property (@(posedge clk) disable iff (!rstN)
    (!rxIntEn && !errIntEn) |-> !irq);

  a_r9_tmo_needs_data: assert property (@(posedge clk) disable iff (!rstN)
    (rxLevel == 8'd0) |=> !intStatus[2]);

endmodule

bind hs_uart_rx hs_uart_rx_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .popReq(popReq), .clrFlags(clrFlags),
  .rxIntEn(rxIntEn), .errIntEn(errIntEn), .popData(popData),
  .rxLevel(rxLevel), .intStatus(intStatus), .irq(irq)
);

// File: tb/hs_uart_rx_bench.sv
module hs_uart_rx_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        serialIn = 1'b1;
  logic [7:0]  rateDiv = 8'd0;
  logic [2:0]  trigSel = 3'd0;
  logic [1:0]  tmoSel = 2'd0;
  logic        rxIntEn = 1'b0;
  logic        errIntEn = 1'b0;
  logic        popReq = 1'b0;
  logic [2:0]  clrFlags = 3'd0;
  logic [31:0] popData;
  logic [7:0]  rxLevel;
  logic [5:0]  intStatus;
  logic        irq;

  always #2.5 clk = ~clk;

  hs_uart_rx u_hs_uart_rx (
    .clk(clk), .rstN(rstN), .serialIn(serialIn), .rateDiv(rateDiv),
    .trigSel(trigSel), .tmoSel(tmoSel), .rxIntEn(rxIntEn), .errIntEn(errIntEn),
    .popReq(popReq), .clrFlags(clrFlags), .popData(popData),
    .rxLevel(rxLevel), .intStatus(intStatus), .irq(irq)
  );

  int nChecks = 0;
  int nFail = 0;
  logic [31:0] expQ[$];
  logic monEn = 1'b0;
  localparam int BITCLK = 14;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pops entries and compares against the scoreboard (R1, R3)
  initial begin
    forever begin
      @(negedge clk);
      popReq = 1'b0;
      if (monEn && rstN && rxLevel != 8'd0) begin
        if (expQ.size() == 0) begin
          chk(1'b0, "R3 unexpected entry", popData, 32'h0);
        end else begin
          logic [31:0] e;
          e = expQ.pop_front();
          chk(popData == e, "R1 R3 popped word", popData, e);
        end
        popReq = 1'b1;
      end
    end
  end

  task automatic sendFrame(input logic [7:0] d, input logic stopBit);
    serialIn = 1'b0;
    repeat (BITCLK) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      serialIn = d[i];
      repeat (BITCLK) @(negedge clk);
    end
    serialIn = stopBit;
    repeat (BITCLK) @(negedge clk);
    serialIn = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic sendByte(input logic [7:0] d, input bit expect_it);
    if (expect_it) expQ.push_back({24'd0, d});
    sendFrame(d, 1'b1);
  endtask

  task automatic drain();
    monEn = 1'b1;
    for (int i = 0; i < 400 && expQ.size() != 0; i++) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(expQ.size() == 0, "R3 scoreboard drained", expQ.size(), 0);
  endtask

  task automatic clearPulse(input logic [2:0] c);
    @(negedge clk);
    clrFlags = c;
    @(negedge clk);
    clrFlags = 3'd0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R12 reset state, R1 empty word
    chk(rxLevel == 8'd0, "R12 level after reset", rxLevel, 0);
    chk(popData == 32'h100, "R1 empty word", popData, 32'h100);
    chk(intStatus == 6'd0, "R12 status after reset", intStatus, 0);
    chk(irq == 1'b0, "R12 irq after reset", irq, 0);

    // R2 bit order and sampling
    monEn = 1'b1;
    sendByte(8'h55, 1'b1);
    sendByte(8'hA3, 1'b1);
    sendByte(8'h00, 1'b1);
    sendByte(8'hFF, 1'b1);
    drain();
    chk(intStatus[4] == 1'b0, "R6 zero byte with good stop is not break", intStatus, 0);

    // R2 slower tick rate
    rateDiv = 8'd1;
    expQ.push_back(32'h0000_00C6);
    serialIn = 1'b0;
    repeat (2 * BITCLK) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      serialIn = 8'hC6 >> i;
      repeat (2 * BITCLK) @(negedge clk);
    end
    serialIn = 1'b1;
    repeat (2 * BITCLK + 6) @(negedge clk);
    drain();
    rateDiv = 8'd0;

    // R10 glitch ignored
    serialIn = 1'b0;
    repeat (3) @(negedge clk);
    serialIn = 1'b1;
    repeat (300) @(negedge clk);
    chk(rxLevel == 8'd0, "R10 glitch stored nothing", rxLevel, 0);

    // R4 trigger, R3 level, R11 masking
    monEn = 1'b0;
    trigSel = 3'd1;
    rxIntEn = 1'b1;
    sendByte(8'h11, 1'b1);
    sendByte(8'h22, 1'b1);
    sendByte(8'h33, 1'b1);
    chk(rxLevel == 8'd3, "R3 level count", rxLevel, 3);
    chk(intStatus[1] == 1'b0, "R4 below threshold 4", intStatus, 0);
    chk(irq == 1'b0, "R11 no irq below threshold", irq, 0);
    sendByte(8'h44, 1'b1);
    chk(intStatus[1] == 1'b1, "R4 at threshold 4", intStatus, 6'h02);
    chk(irq == 1'b1, "R11 irq on trigger", irq, 1);
    rxIntEn = 1'b0;
    @(negedge clk);
    chk(irq == 1'b0, "R11 trigger masked", irq, 0);
    drain();
    chk(intStatus[1] == 1'b0, "R4 trigger drops when empty", intStatus, 0);

    // R5 framing error and R7 clear
    errIntEn = 1'b1;
    expQ.push_back(32'h0000_023C);
    sendFrame(8'h3C, 1'b0);
    drain();
    chk(intStatus[3] == 1'b1, "R5 framing flag", intStatus, 6'h08);
    chk(irq == 1'b1, "R11 irq on framing", irq, 1);
    clearPulse(3'b001);
    chk(intStatus[3] == 1'b0, "R7 framing cleared", intStatus, 0);
    chk(irq == 1'b0, "R11 irq gone after clear", irq, 0);

    // R6 break
    expQ.push_back(32'h0000_0400);
    serialIn = 1'b0;
    repeat (200) @(negedge clk);
    serialIn = 1'b1;
    repeat (20) @(negedge clk);
    drain();
    chk(intStatus[4] == 1'b1, "R6 break flag", intStatus, 6'h10);
    chk(intStatus[3] == 1'b0, "R6 break not framing", intStatus, 6'h10);
    clearPulse(3'b010);
    chk(intStatus[4] == 1'b0, "R7 break cleared", intStatus, 0);

    // R8 overrun
    monEn = 1'b0;
    for (int i = 0; i < 64; i++) sendByte(8'((i * 7 + 1) & 8'hFF), 1'b1);
    chk(rxLevel == 8'd64, "R3 FIFO full at 64", rxLevel, 64);
    chk(intStatus[5] == 1'b0, "R8 no overrun at 64", intStatus, 0);
    sendByte(8'hEE, 1'b0);
    chk(rxLevel == 8'd64, "R8 level held at 64", rxLevel, 64);
    chk(intStatus[5] == 1'b1, "R8 overrun flag", intStatus, 6'h20);
    chk(irq == 1'b1, "R11 irq on overrun", irq, 1);
    drain();
    chk(rxLevel == 8'd0, "R8 drained", rxLevel, 0);
    clearPulse(3'b100);
    chk(intStatus[5] == 1'b0, "R7 overrun cleared", intStatus, 0);

    // R9 timeout
    trigSel = 3'd4;
    rxIntEn = 1'b1;
    tmoSel = 2'd0;
    sendByte(8'h5A, 1'b1);
    repeat (700) @(negedge clk);
    chk(intStatus[2] == 1'b0, "R9 disabled timeout", intStatus, 0);
    drain();

    tmoSel = 2'd1;
    monEn = 1'b0;
    sendByte(8'h6B, 1'b1);
    repeat (540) @(negedge clk);
    chk(intStatus[2] == 1'b0, "R9 before 4 chars", intStatus, 0);
    repeat (40) @(negedge clk);
    chk(intStatus[2] == 1'b1, "R9 after 4 chars", intStatus, 6'h04);
    chk(irq == 1'b1, "R11 irq on timeout", irq, 1);
    drain();
    chk(intStatus[2] == 1'b0, "R9 cleared by pop", intStatus, 0);

    tmoSel = 2'd3;
    monEn = 1'b0;
    sendByte(8'h7C, 1'b1);
    repeat (2200) @(negedge clk);
    chk(intStatus[2] == 1'b0, "R9 before 16 chars", intStatus, 0);
    repeat (80) @(negedge clk);
    chk(intStatus[2] == 1'b1, "R9 after 16 chars", intStatus, 6'h04);
    drain();

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule